// File: doc/BRIEF.md
# Freeze-and-Catch-Up Real-Time Tick Counter

This block holds a 40-bit real-time tick counter that software reads one byte at a time through a small byte-addressed register port. The port stands in for a serial bus slave. An address phase loads a register pointer. Read strobes return the byte at the pointer and then step the pointer up by one. A separate stop strobe marks the end of a bus transaction.

A multi-byte read has to see one consistent value. To get that, the counter halts while a read of its bytes is in progress. Ticks that arrive while it is halted go into a small secondary counter. When the read transaction ends, the secondary count and any tick in that same cycle are added back to the main counter in one step, so no time is lost.

The secondary counter can cover only a short suspend. If it fills, it saturates, and a sticky overflow flag records that accuracy has been lost.

Top module: `rtc_lock_counter`

## Requirements
- R1: After reset the counter is 0, the lock is released, the secondary counter is 0, `ovf_o` is 0 and `rdata_o` is 0.
- R2: While unlocked, each cycle with `tick_i` high increments the counter by one, modulo 2^40.
- R3: An address phase (`ptr_set_i`) that loads the pointer with the counter's top address (0x40) locks the counter. A stop that ends that address-only transaction does not release the lock. While locked, the counter value does not change.
- R4: While locked, each tick increments the secondary counter instead of the main counter. On release, the main counter becomes its held value plus the secondary count plus the tick of the release cycle, and the secondary counter returns to 0.
- R5: An address phase at any address other than 0x40 does not lock the counter. A read strobe at pointer 0x40 while unlocked locks the counter from that cycle on, and that tick already goes to the secondary counter. A stop after at least one read under the lock releases it.
- R6: The counter bytes sit at addresses 0x40 to 0x44, with the most significant byte at 0x40. A read returns the byte at the pointer on `rdata_o` one cycle after the strobe, and then increments the pointer.
- R7: The secondary counter saturates at 63. A tick that arrives while it is full is lost and sets `ovf_o`, which stays at 1 until reset. `ovf_o` also reads as bit 0 at address 0x3F.
- R8: Reads at any address other than 0x3F to 0x44 return 0x00. Such reads, and stops while unlocked, leave the lock and the counter unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle tick pulse from the prescaler |
| ptr_set_i | input | 1 | Address phase: load the pointer from `addr_i` |
| addr_i | input | 8 | Register address for `ptr_set_i` |
| rd_i | input | 1 | Read strobe: return the byte at the pointer, then increment the pointer |
| stop_i | input | 1 | End of transaction |
| rdata_o | output | 8 | Read data, valid one cycle after `rd_i` |
| ovf_o | output | 1 | Sticky flag: secondary counter overflowed |

## Verification
The embedded assertions check these rules on every cycle:
- the counter does not move while the lock is held;
- it advances by exactly one on a free-running tick;
- the catch-up sum is correct on release;
- the secondary counter clears on release, saturates when full, and the overflow flag is sticky;
- the lock arms and holds correctly, and the pointer steps up on each read.

Only the bench scenarios can show that a full five-byte read is consistent end to end. They also show the difference between arming by address phase and arming by read, that an address-only transaction leaves the lock set across its stop, and that the total elapsed ticks are conserved over many mixed transactions.

// File: rtl/rtc_pkg.sv
// Package: shared types for the freeze-and-catch-up tick counter.
// Assumes one bus strobe per cycle at most (address phase, read or stop).
package rtc_pkg;
    typedef logic [7:0] rtc_byte_t;

    // Lock state: free-running, held by an address-only phase, held with a read seen
    typedef enum logic [1:0] {
        LK_FREE    = 2'd0,
        LK_ARMED   = 2'd1,
        LK_READING = 2'd2
    } lock_state_t;
endpackage

// File: rtl/rtc_lock_ctrl.sv
// Module: lock controller. Decides when the counter is held and when the
// held ticks are released. An address phase at the top byte arms the lock,
// and so does a read that reaches the top byte. The lock is released only
// by a stop that follows at least one read made under the lock.
// Assumes ptr_set_i, rd_i and stop_i are never high in the same cycle.
module rtc_lock_ctrl
    import rtc_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int TOP_ADDR = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_set_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              stop_i,
    input  logic [ADDR_W-1:0] ptr_i,
    output logic              hold_o,
    output logic              release_o
);
    localparam logic [ADDR_W-1:0] TOP = ADDR_W'(TOP_ADDR);

    lock_state_t state_q, state_d;
    logic        arm_wr, arm_rd;

    // Arming conditions seen while the counter is free-running
    always_comb begin
        arm_wr = (state_q == LK_FREE) && ptr_set_i && (addr_i == TOP);
        arm_rd = (state_q == LK_FREE) && !ptr_set_i && rd_i && (ptr_i == TOP);
    end

    // Next state of the lock
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_FREE: begin
                if (arm_wr)      state_d = LK_ARMED;
                else if (arm_rd) state_d = LK_READING;
            end
            LK_ARMED:   if (rd_i)   state_d = LK_READING;
            LK_READING: if (stop_i) state_d = LK_FREE;
            default:    state_d = LK_FREE;
        endcase
    end

    // Lock state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_FREE;
        else        state_q <= state_d;
    end

    // The hold covers the arming cycle itself
    assign hold_o    = (state_q != LK_FREE) || arm_wr || arm_rd;
    assign release_o = (state_q == LK_READING) && stop_i;

    AST_ARM_ON_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_FREE && ptr_set_i && addr_i == TOP) |=> (state_q == LK_ARMED)); // R3
    AST_WRITE_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_ARMED && stop_i) |=> (state_q == LK_ARMED)); // R3
    AST_NO_ARM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_FREE && ptr_set_i && addr_i != TOP) |=> (state_q == LK_FREE)); // R5
    AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |=> (state_q == LK_FREE)); // R5
endmodule

// File: rtl/rtc_catchup.sv
// Module: secondary catch-up counter. Collects ticks while the main counter
// is held, saturates at its maximum, and sets a sticky overflow flag when a
// tick is lost. It clears on release, when its count is handed to the main
// counter.
module rtc_catchup #(
    parameter int SEC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             hold_i,
    input  logic             release_i,
    output logic [SEC_W-1:0] sec_o,
    output logic             ovf_o
);
    localparam logic [SEC_W-1:0] SEC_MAX = {SEC_W{1'b1}};

    // Count held ticks with saturation; release has priority
    always_ff @(posedge clk) begin
        if (!rst_n)                                      sec_o <= '0;
        else if (release_i)                              sec_o <= '0;
        else if (hold_i && tick_i && sec_o != SEC_MAX)   sec_o <= sec_o + 1'b1;
    end

    // Sticky overflow when a held tick finds the counter full
    always_ff @(posedge clk) begin
        if (!rst_n)                                             ovf_o <= 1'b0;
        else if (!release_i && hold_i && tick_i && sec_o == SEC_MAX) ovf_o <= 1'b1;
    end

    AST_SEC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |=> (sec_o == '0)); // R4
    AST_SEC_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!release_i && hold_i && tick_i && sec_o == SEC_MAX) |=> (sec_o == SEC_MAX && ovf_o)); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o); // R7
endmodule

// File: rtl/rtc_main_cnt.sv
// Module: main tick counter. Increments on free-running ticks and stays
// still while held. On release it adds the catch-up count plus the tick
// of the release cycle in a single step.
module rtc_main_cnt #(
    parameter int CNT_W = 40,
    parameter int SEC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             hold_i,
    input  logic             release_i,
    input  logic [SEC_W-1:0] sec_i,
    output logic [CNT_W-1:0] count_o
);
    // Advance, hold or catch up the visible count
    always_ff @(posedge clk) begin
        if (!rst_n)               count_o <= '0;
        else if (release_i)       count_o <= count_o + CNT_W'(sec_i) + CNT_W'(tick_i);
        else if (!hold_i && tick_i) count_o <= count_o + 1'b1;
    end

    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !release_i) |=> $stable(count_o)); // R3
    AST_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && tick_i) |=> (count_o == CNT_W'($past(count_o) + 1'b1))); // R2
    AST_CATCHUP: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |=> (count_o == CNT_W'($past(count_o) + CNT_W'($past(sec_i)) + CNT_W'($past(tick_i))))); // R4
endmodule

// File: rtl/rtc_reg_port.sv
// Module: byte register port. Holds the auto-incrementing pointer and
// returns the addressed byte one cycle after a read strobe. The counter
// sits most significant byte first from TOP_ADDR upward. The status byte
// sits just below it, and every other address reads as zero.
module rtc_reg_port
    import rtc_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int TOP_ADDR  = 8'h40,
    parameter int CNT_BYTES = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ptr_set_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic                   rd_i,
    input  logic [CNT_BYTES*8-1:0] count_i,
    input  logic                   ovf_i,
    output logic [ADDR_W-1:0]      ptr_o,
    output rtc_byte_t              rdata_o
);
    localparam logic [ADDR_W-1:0] STAT = ADDR_W'(TOP_ADDR - 1);

    rtc_byte_t sel;

    // Select the byte that the pointer addresses
    always_comb begin
        sel = '0;
        if (ptr_o == STAT) sel = {7'b0, ovf_i};
        for (int i = 0; i < CNT_BYTES; i++) begin
            if (ptr_o == ADDR_W'(TOP_ADDR + i)) sel = count_i[(CNT_BYTES-1-i)*8 +: 8];
        end
    end

    // Pointer: load on address phase, step on each read
    always_ff @(posedge clk) begin
        if (!rst_n)         ptr_o <= '0;
        else if (ptr_set_i) ptr_o <= addr_i;
        else if (rd_i)      ptr_o <= ptr_o + 1'b1;
    end

    // Registered read data
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata_o <= '0;
        else if (rd_i) rdata_o <= sel;
    end

    AST_PTR_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !ptr_set_i) |=> (ptr_o == ADDR_W'($past(ptr_o) + 1'b1))); // R6
endmodule

// File: rtl/rtc_lock_counter.sv
// Module: top of the freeze-and-catch-up tick counter. Connects the lock
// controller, the catch-up counter, the main counter and the register port.
// Assumes tick_i is a single-cycle pulse at most once per clock.
module rtc_lock_counter
    import rtc_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int TOP_ADDR  = 8'h40,
    parameter int CNT_BYTES = 5,
    parameter int SEC_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              ptr_set_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              stop_i,
    output logic [7:0]        rdata_o,
    output logic              ovf_o
);
    localparam int CNT_W = CNT_BYTES * 8;

    logic              hold, release_now;
    logic [SEC_W-1:0]  sec;
    logic [CNT_W-1:0]  count;
    logic [ADDR_W-1:0] ptr;

    rtc_lock_ctrl #(.ADDR_W(ADDR_W), .TOP_ADDR(TOP_ADDR)) u_lock (
        .clk(clk), .rst_n(rst_n), .ptr_set_i(ptr_set_i), .addr_i(addr_i),
        .rd_i(rd_i), .stop_i(stop_i), .ptr_i(ptr),
        .hold_o(hold), .release_o(release_now));

    rtc_catchup #(.SEC_W(SEC_W)) u_sec (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .hold_i(hold),
        .release_i(release_now), .sec_o(sec), .ovf_o(ovf_o));

    rtc_main_cnt #(.CNT_W(CNT_W), .SEC_W(SEC_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .hold_i(hold),
        .release_i(release_now), .sec_i(sec), .count_o(count));

    rtc_reg_port #(.ADDR_W(ADDR_W), .TOP_ADDR(TOP_ADDR), .CNT_BYTES(CNT_BYTES)) u_port (
        .clk(clk), .rst_n(rst_n), .ptr_set_i(ptr_set_i), .addr_i(addr_i),
        .rd_i(rd_i), .count_i(count), .ovf_i(ovf_o), .ptr_o(ptr), .rdata_o(rdata_o));
endmodule

// File: tb/sim_rtc_lock_counter.sv
`timescale 1ns/1ps
module sim_rtc_lock_counter;
    localparam logic [7:0] TOP = 8'h40;
    localparam longint unsigned MASK = (64'd1 << 40) - 1;

    logic clk = 1'b0;
    logic rst_n, tick_i, ptr_set_i, rd_i, stop_i;
    logic [7:0] addr_i;
    logic [7:0] rdata_o;
    logic ovf_o;
    int tests = 0, fails = 0;
    bit done = 0;

    // Bench model state
    longint unsigned m_cnt;
    int m_sec, m_state;
    bit m_ovf;
    logic [7:0] m_ptr;

    always #2 clk = ~clk;

    rtc_lock_counter u0 (.clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ptr_set_i(ptr_set_i),
        .addr_i(addr_i), .rd_i(rd_i), .stop_i(stop_i), .rdata_o(rdata_o), .ovf_o(ovf_o));

    function automatic logic [7:0] exp_byte(longint unsigned c, logic [7:0] p, bit ov);
        if (p == TOP - 8'd1) return {7'b0, ov};
        if (p >= TOP && p < TOP + 8'd5) return 8'(c >> (8 * (4 - int'(p - TOP))));
        return 8'h00;
    endfunction

    task automatic check(string tag, longint unsigned act, longint unsigned exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive, update the model, check read data after the edge
    task automatic cyc(bit ps, bit rd, bit st, bit tk, logic [7:0] a, string tag);
        logic [7:0] e;
        bit arm, hold, rel;
        @(negedge clk);
        ptr_set_i = ps; rd_i = rd; stop_i = st; tick_i = tk; addr_i = a;
        e = exp_byte(m_cnt, m_ptr, m_ovf);
        arm  = (m_state == 0) && ((ps && a == TOP) || (!ps && rd && m_ptr == TOP));
        hold = (m_state != 0) || arm;
        rel  = (m_state == 2) && st;
        if (rel) begin
            m_cnt = (m_cnt + longint'(m_sec) + longint'(tk)) & MASK;
            m_sec = 0; m_state = 0;
        end else begin
            if (tk) begin
                if (hold) begin
                    if (m_sec == 63) m_ovf = 1; else m_sec++;
                end else m_cnt = (m_cnt + 1) & MASK;
            end
            if (arm) m_state = ps ? 1 : 2;
            else if (m_state == 1 && rd) m_state = 2;
        end
        if (ps) m_ptr = a; else if (rd) m_ptr = m_ptr + 8'd1;
        @(posedge clk); #1;
        if (rd) check(tag, rdata_o, e);
    endtask

    task automatic idle(int n, bit tk, string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, tk, 8'h00, tag);
    endtask

    // Full transaction: address phase, n reads, stop; rnd adds random ticks
    task automatic burst(logic [7:0] a, int n, bit rnd, string tag);
        cyc(1, 0, 0, rnd && ($urandom % 3 == 0), a, tag);
        for (int i = 0; i < n; i++) cyc(0, 1, 0, rnd && ($urandom % 3 == 0), 8'h00, tag);
        cyc(0, 0, 1, rnd && ($urandom % 3 == 0), 8'h00, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; tick_i = 0; ptr_set_i = 0; rd_i = 0; stop_i = 0; addr_i = 0;
        m_cnt = 0; m_sec = 0; m_state = 0; m_ovf = 0; m_ptr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        check("R1 rdata after reset", rdata_o, 0);
        check("R1 ovf after reset", ovf_o, 0);
        burst(TOP, 5, 0, "R1 count zero");

        // R2: free-running ticks
        idle(10, 1, "R2");
        burst(TOP, 5, 0, "R2 count after ticks");

        // R3: address-only phase arms; its stop keeps the lock
        cyc(1, 0, 0, 0, TOP, "R3");
        cyc(0, 0, 1, 1, 8'h00, "R3");
        idle(8, 1, "R3");
        cyc(1, 0, 0, 1, TOP, "R3");
        for (int i = 0; i < 5; i++) cyc(0, 1, 0, 1, 8'h00, "R3 frozen byte");
        cyc(0, 0, 1, 1, 8'h00, "R4");
        burst(TOP - 8'd1, 6, 0, "R4 caught-up count");

        // R5: start below top, lock from the top byte read
        cyc(1, 0, 0, 1, TOP - 8'd1, "R5");
        cyc(0, 1, 0, 1, 8'h00, "R5 status byte");
        for (int i = 0; i < 5; i++) cyc(0, 1, 0, 1, 8'h00, "R5 frozen byte");
        cyc(0, 0, 1, 1, 8'h00, "R5");
        burst(TOP, 5, 0, "R5 count after release");

        // R6: burst past the last counter byte
        idle(3, 1, "R6");
        burst(TOP + 8'd2, 5, 0, "R6 auto-increment");

        // R8: other addresses and lone stops do nothing
        cyc(1, 0, 0, 1, 8'h10, "R8");
        for (int i = 0; i < 4; i++) cyc(0, 1, 0, 1, 8'h00, "R8 unmapped read");
        cyc(0, 0, 1, 1, 8'h00, "R8");
        cyc(0, 0, 1, 1, 8'h00, "R8");
        burst(TOP, 5, 0, "R8 count still running");

        // Random mix of transactions
        for (int k = 0; k < 300; k++) begin
            int sel = $urandom % 4;
            logic [7:0] a = (sel == 0) ? TOP : (sel == 1) ? TOP - 8'd1 :
                            (sel == 2) ? TOP + 8'($urandom % 5) : 8'($urandom);
            if ($urandom % 4 == 0) begin
                cyc(1, 0, 0, $urandom % 2 == 0, a, "R3 random");
                cyc(0, 0, 1, $urandom % 2 == 0, 8'h00, "R3 random");
                idle($urandom % 6, $urandom % 2 == 0, "R3 random");
            end
            burst(a, 1 + $urandom % 6, 1, "R6 random burst");
            idle($urandom % 4, 1, "R2 random");
        end
        burst(TOP, 5, 0, "R4 total conserved");

        // R7: saturation and sticky overflow
        cyc(1, 0, 0, 0, TOP, "R7");
        idle(70, 1, "R7");
        check("R7 ovf set", ovf_o, 1);
        for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0, 8'h00, "R7 frozen byte");
        cyc(0, 0, 1, 0, 8'h00, "R7");
        burst(TOP - 8'd1, 6, 0, "R7 saturated catch-up");
        idle(5, 1, "R7");
        check("R7 ovf sticky", ovf_o, 1);
        idle(2, 0, "end");
        finish_run();
    end
endmodule